// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries out the memory side of exception entry for a small 32-bit processor. The instruction decoder raises one of three request kinds when it decodes the offending instruction:
- a software trap, which carries an 8-bit vector number;
- an illegal instruction found in a delay slot;
- an undefined opcode found anywhere else.

The sequencer takes a snapshot of the status word, stack pointer and vector base. It also takes the return address that suits the kind. It then runs a fixed sequence of three accesses on a single-port request/acknowledge memory interface:
1. push the status word;
2. push the return address;
3. read the handler address from the vector table.

Each push moves the stack pointer down by one word first. The new stack pointer goes back to the register file through a one-cycle write strobe. The fetched handler address goes to the program counter through a one-cycle load strobe, together with a completion pulse. The jump is immediate: no slot instruction follows it.

Deciding which instruction is illegal stays in the decoder. This includes an instruction that rewrites the program counter while it sits in a delay slot. The sequencer only acts on the kind it is given.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, busy, mem_req, sp_we, pc_we and done are all low.
- R2: The first access after a request is accepted is a write of the captured status word (sr_in) to address sp_in - 4.
- R3: The second access is a write of the return address to address sp_in - 8, so the status word lies above it.
- R4: For a trap (req_kind 2'b00) the return address is req_pc + 2, the address of the following instruction.
- R5: For an illegal delay-slot instruction (req_kind 2'b01) the return address is req_branch_tgt, the target of the delayed branch before the slot.
- R6: For a general illegal instruction (req_kind 2'b10) the return address is req_pc, the address of the undefined opcode.
- R7: The third access is a read at vbr_in + 4 * N. N is req_trap_vec for a trap, 6 for an illegal slot and 4 for a general illegal instruction. The sum wraps modulo 2^32.
- R8: One cycle after the read is acknowledged:
  - pc_we and done are high for exactly one cycle;
  - pc_out holds the read data;
  - busy falls;
  - no further memory access follows.
- R9: sp_we pulses once per acknowledged push, one cycle after the acknowledge. sp_out then holds the address just written, and the last value is sp_in - 8.
- R10: A request that arrives while busy is high is ignored, and so is req_kind 2'b11. Neither one changes the memory accesses or starts a sequence.
- R11: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request from the decoder |
| req_kind | input | 2 | 00 trap, 01 illegal slot, 10 general illegal, 11 none |
| req_trap_vec | input | 8 | Trap vector number |
| req_pc | input | 32 | Address of the instruction being decoded |
| req_branch_tgt | input | 32 | Target of the preceding delayed branch |
| sr_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 32 | New stack pointer value |
| pc_we | output | 1 | Program counter load strobe |
| pc_out | output | 32 | Handler address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume the following of the inputs:
- the memory returns mem_rdata in the same cycle as mem_ack;
- mem_ack is raised only while mem_req is high;
- sr_in and sp_in are stable in the cycle a request is accepted.

The bench's memory model decides acknowledges on the falling edge, and only while a request is pending, with a random stall of zero or more cycles. The request driver changes inputs only between edges. Requests that intrude while busy, and the unused kind code, are injected on purpose, so that the ignore rule is exercised at the ports.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [1:0] {
        KIND_TRAP = 2'b00,
        KIND_SLOT = 2'b01,
        KIND_GEN  = 2'b10,
        KIND_NONE = 2'b11
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH
    } seq_state_e;

endpackage

// File: rtl/exc_ret_sel.sv
module exc_ret_sel
    import exc_seq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 2
) (
    input  exc_kind_e        kind,
    input  logic [XLEN-1:0]  insn_pc,
    input  logic [XLEN-1:0]  branch_tgt,
    output logic [XLEN-1:0]  ret_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        case (kind)
            KIND_TRAP: ret_addr = insn_pc + STEP;
            KIND_SLOT: ret_addr = branch_tgt;
            default:   ret_addr = insn_pc;
        endcase
    end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
    import exc_seq_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VEC_W    = 8,
    parameter int SLOT_VEC = 6,
    parameter int ILL_VEC  = 4
) (
    input  exc_kind_e        kind,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [XLEN-1:0]  table_base,
    output logic [XLEN-1:0]  entry_addr
);
    localparam int WORD_SHIFT = $clog2(XLEN / 8);

    logic [VEC_W-1:0] vec_num;

    always_comb begin
        case (kind)
            KIND_TRAP: vec_num = trap_vec;
            KIND_SLOT: vec_num = VEC_W'(SLOT_VEC);
            default:   vec_num = VEC_W'(ILL_VEC);
        endcase
        entry_addr = table_base + (XLEN'(vec_num) << WORD_SHIFT);
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int VEC_W      = 8,
    parameter int INSN_BYTES = 2,
    parameter int SLOT_VEC   = 6,
    parameter int ILL_VEC    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [VEC_W-1:0] req_trap_vec,
    input  logic [XLEN-1:0]  req_pc,
    input  logic [XLEN-1:0]  req_branch_tgt,
    input  logic [XLEN-1:0]  sr_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  vbr_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_out,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_out,
    output logic             busy,
    output logic             done
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

    typedef struct packed {
        seq_state_e      state;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] ret;
        logic [XLEN-1:0] vaddr;
        logic [XLEN-1:0] pc;
        logic            sp_we;
        logic            pc_we;
        logic            done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    exc_kind_e kind_w;
    logic [XLEN-1:0] ret_w, vaddr_w, push_addr;

    assign kind_w = exc_kind_e'(req_kind);

    exc_ret_sel #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret_sel (
        .kind       (kind_w),
        .insn_pc    (req_pc),
        .branch_tgt (req_branch_tgt),
        .ret_addr   (ret_w)
    );

    exc_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W), .SLOT_VEC(SLOT_VEC), .ILL_VEC(ILL_VEC)) u_vec_addr (
        .kind       (kind_w),
        .trap_vec   (req_trap_vec),
        .table_base (vbr_in),
        .entry_addr (vaddr_w)
    );

    assign push_addr = seq_q.sp - WORD_BYTES;

    always_comb begin
        seq_d       = seq_q;
        seq_d.sp_we = 1'b0;
        seq_d.pc_we = 1'b0;
        seq_d.done  = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid && kind_w != KIND_NONE) begin
                    seq_d.state = ST_PUSH_SR;
                    seq_d.sp    = sp_in;
                    seq_d.sr    = sr_in;
                    seq_d.ret   = ret_w;
                    seq_d.vaddr = vaddr_w;
                end
            end
            ST_PUSH_SR: begin
                if (mem_ack) begin
                    seq_d.sp    = push_addr;
                    seq_d.sp_we = 1'b1;
                    seq_d.state = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: begin
                if (mem_ack) begin
                    seq_d.sp    = push_addr;
                    seq_d.sp_we = 1'b1;
                    seq_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    seq_d.pc    = mem_rdata;
                    seq_d.pc_we = 1'b1;
                    seq_d.done  = 1'b1;
                    seq_d.state = ST_IDLE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (seq_q.state == ST_PUSH_SR) || (seq_q.state == ST_PUSH_PC);
    assign mem_addr  = (seq_q.state == ST_FETCH) ? seq_q.vaddr : push_addr;
    assign mem_wdata = (seq_q.state == ST_PUSH_SR) ? seq_q.sr : seq_q.ret;
    assign sp_we     = seq_q.sp_we;
    assign sp_out    = seq_q.sp;
    assign pc_we     = seq_q.pc_we;
    assign pc_out    = seq_q.pc;
    assign done      = seq_q.done;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] sr_in,
    input logic [XLEN-1:0] sp_in,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ack,
    input logic [XLEN-1:0] mem_rdata,
    input logic            sp_we,
    input logic [XLEN-1:0] sp_out,
    input logic            pc_we,
    input logic [XLEN-1:0] pc_out,
    input logic            busy,
    input logic            done
);
    localparam logic [XLEN-1:0] WB = XLEN'(XLEN / 8);

    assert_first_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && mem_we && mem_wdata == $past(sr_in) && mem_addr == $past(sp_in) - WB));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || pc_we) |-> !busy);

    assert_pc_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (pc_out == $past(mem_rdata) && $past(mem_req && mem_ack && !mem_we)));

    assert_sp_from_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (sp_out == $past(mem_addr) && $past(mem_req && mem_ack && mem_we)));

    assert_strobes_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sp_we, pc_we}));

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_in     (sr_in),
    .sp_in     (sp_in),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .sp_we     (sp_we),
    .sp_out    (sp_out),
    .pc_we     (pc_we),
    .pc_out    (pc_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [7:0]  req_trap_vec = '0;
    logic [31:0] req_pc = '0, req_branch_tgt = '0, sr_in = '0, sp_in = '0, vbr_in = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        sp_we, pc_we, busy, done;
    logic [31:0] sp_out, pc_out;

    always #2 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_trap_vec(req_trap_vec), .req_pc(req_pc), .req_branch_tgt(req_branch_tgt),
        .sr_in(sr_in), .sp_in(sp_in), .vbr_in(vbr_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .sp_we(sp_we), .sp_out(sp_out), .pc_we(pc_we), .pc_out(pc_out),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] tr_addr [8];
    logic [31:0] tr_data [8];
    logic        tr_we   [8];
    int          tr_n = 0;
    int          sp_cnt = 0;
    int          done_cnt = 0;
    logic [31:0] last_sp = '0;
    logic [31:0] seen_pc = '0;
    logic        seen_pcwe = 1'b0;
    bit          prev_wait = 1'b0;
    logic [31:0] wait_addr = '0, wait_data = '0;
    logic        wait_we = 1'b0;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] exp_ret(input logic [1:0] k, input logic [31:0] pc, input logic [31:0] tgt);
        if (k == 2'b00) return pc + 32'd2;
        if (k == 2'b01) return tgt;
        return pc;
    endfunction

    function automatic logic [31:0] exp_vaddr(input logic [1:0] k, input logic [7:0] v, input logic [31:0] vbr);
        logic [31:0] n;
        n = (k == 2'b00) ? {24'd0, v} : ((k == 2'b01) ? 32'd6 : 32'd4);
        return vbr + (n << 2);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and output monitor, all on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack   = 1'b0;
            prev_wait = 1'b0;
        end else begin
            if (sp_we) begin sp_cnt++; last_sp = sp_out; end
            if (done) begin done_cnt++; seen_pc = pc_out; seen_pcwe = pc_we; end
            if (prev_wait && mem_req) begin
                chk(mem_addr == wait_addr && mem_we == wait_we && mem_wdata == wait_data,
                    "R11 request held while stalled", mem_addr, wait_addr);
            end
            mem_ack   = 1'b0;
            prev_wait = 1'b0;
            if (mem_req) begin
                if ($urandom % 3 != 0) begin
                    if (tr_n < 8) begin
                        tr_addr[tr_n] = mem_addr;
                        tr_data[tr_n] = mem_wdata;
                        tr_we[tr_n]   = mem_we;
                    end
                    tr_n++;
                    mem_ack = 1'b1;
                    if (!mem_we) mem_rdata = mem_val(mem_addr);
                end else begin
                    prev_wait = 1'b1;
                    wait_addr = mem_addr;
                    wait_we   = mem_we;
                    wait_data = mem_wdata;
                end
            end
        end
    end

    task automatic run_one(input logic [1:0] k, input logic [7:0] v, input logic [31:0] pc,
                           input logic [31:0] tgt, input logic [31:0] sr, input logic [31:0] sp,
                           input logic [31:0] vbr, input bit intrude);
        string rtag;
        logic [31:0] va;
        int w;
        @(negedge clk);
        tr_n = 0; sp_cnt = 0; done_cnt = 0; seen_pcwe = 1'b0;
        req_valid = 1'b1; req_kind = k; req_trap_vec = v; req_pc = pc;
        req_branch_tgt = tgt; sr_in = sr; sp_in = sp; vbr_in = vbr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
        if (intrude) begin
            // R10: second request while busy, with different values
            req_valid = 1'b1; req_kind = 2'b00; req_trap_vec = ~v; req_pc = ~pc;
            sr_in = ~sr; sp_in = sp ^ 32'h0000_1000; vbr_in = ~vbr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        w = 0;
        while (done_cnt == 0 && w < 200) begin @(negedge clk); w++; end
        repeat (3) @(negedge clk);
        rtag = (k == 2'b00) ? "R4 trap return" : ((k == 2'b01) ? "R5 slot return" : "R6 general return");
        va = exp_vaddr(k, v, vbr);
        chk(tr_n == 3, "R8/R10 access count", 32'(tr_n), 32'd3);
        if (tr_n >= 3) begin
            chk(tr_we[0] && tr_addr[0] == sp - 32'd4, "R2 first push addr", tr_addr[0], sp - 32'd4);
            chk(tr_data[0] == sr, "R2 first push data", tr_data[0], sr);
            chk(tr_we[1] && tr_addr[1] == sp - 32'd8, "R3 second push addr", tr_addr[1], sp - 32'd8);
            chk(tr_data[1] == exp_ret(k, pc, tgt), rtag, tr_data[1], exp_ret(k, pc, tgt));
            chk(!tr_we[2] && tr_addr[2] == va, "R7 vector read addr", tr_addr[2], va);
        end
        chk(seen_pcwe && seen_pc == mem_val(va), "R8 pc load", seen_pc, mem_val(va));
        chk(done_cnt == 1, "R8 single done", 32'(done_cnt), 32'd1);
        chk(busy == 1'b0, "R8 busy cleared", 32'(busy), 32'd0);
        chk(sp_cnt == 2 && last_sp == sp - 32'd8, "R9 stack pointer update", last_sp, sp - 32'd8);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        chk(!busy && !mem_req && !sp_we && !pc_we && !done, "R1 outputs in reset",
            {27'd0, busy, mem_req, sp_we, pc_we, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !sp_we && !pc_we && !done, "R1 outputs after reset",
            {27'd0, busy, mem_req, sp_we, pc_we, done}, 32'd0);

        run_one(2'b00, 8'h21, 32'h0000_1000, 32'h0000_2000, 32'h0000_00F0, 32'h0FFF_F000, 32'h0000_0000, 1'b0);
        run_one(2'b01, 8'h00, 32'h0000_1234, 32'h0000_4440, 32'h0000_0301, 32'h0800_0000, 32'h0001_0000, 1'b0);
        run_one(2'b10, 8'hFF, 32'h0000_5556, 32'h0000_9990, 32'h0000_000F, 32'h0800_0100, 32'h0001_0000, 1'b0);
        run_one(2'b00, 8'h00, 32'hFFFF_FFFE, 32'h0, 32'hAAAA_5555, 32'h0000_2000, 32'h0000_4000, 1'b0);
        run_one(2'b00, 8'hFF, 32'h0000_0100, 32'h0, 32'h1234_5678, 32'h0000_0004, 32'hFFFF_FF00, 1'b0);
        run_one(2'b01, 8'h10, 32'h0000_0200, 32'h0000_0AAA, 32'h0, 32'h0000_0000, 32'hFFFF_FFF0, 1'b1);
        run_one(2'b10, 8'h10, 32'h0000_0300, 32'h0, 32'h7, 32'h0001_0000, 32'h0000_0800, 1'b1);

        // R10: the unused kind code starts nothing
        @(negedge clk);
        tr_n = 0;
        req_valid = 1'b1; req_kind = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10 kind 11 ignored busy", 32'(busy), 32'd0);
        chk(tr_n == 0, "R10 kind 11 no access", 32'(tr_n), 32'd0);

        for (int i = 0; i < 60; i++) begin
            logic [1:0] k;
            k = 2'($urandom % 3);
            run_one(k, 8'($urandom), $urandom & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFE,
                    $urandom, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FC00, 1'($urandom % 2));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule